// File: doc/BRIEF.md
# Bit-Serial Multiply-Accumulate Element

This block is the arithmetic core of one processing element in a wide array of identical elements. It holds an 8-bit unsigned multiplicand in a register. It multiplies that value by a multiplier of any length, which arrives one bit per clock, least significant bit first. The product leaves as a serial stream at the same rate, one bit per step and least significant bit first. Each step gates the multiplicand through AND logic into an adder, using the incoming multiplier bit as the gate. The adder sums it with the accumulator. The lowest sum bit is emitted, and the rest is kept, shifted down by one place.

When the last multiplier bit has been taken, the element shifts out the high product bits held in the accumulator over extra flush steps, one per multiplicand bit. A chaining input lets the caller skip the flush at the end of one multiply and keep the accumulator at the start of the next. The next stream then carries its own product plus the high part left over from the previous one, which gives a true multiply-accumulate across words.

Top module: `serial_mac`

## Requirements
- R1: After reset, `prodValid` is 0 and the accumulator is zero, so a first multiply that asks to keep the accumulator still yields the plain product.
- R2: `mcandLoad` high at a clock edge stores `mcandIn` as the multiplicand. A load made in the final flush cycle of one multiply applies to a multiply whose first bit follows with no gap.
- R3: A multiplier bit is accepted in a cycle where `bitValid` is 1 and no flush is running. One cycle later `prodValid` is 1 and `prodBit` carries the next product bit.
- R4: For an unflagged multiply of N accepted bits, the element emits exactly N+8 contiguous valid bits. These are the unsigned product, least significant bit first, and the last 8 come from flush cycles.
- R5: N may be any length, including 1 (start and last flags on the same bit) and lengths far beyond 8 bits.
- R6: On a start bit with `accumMode` low, the accumulator is cleared before the add, whatever a previous chained multiply left in it.
- R7: `accumMode` high on the last bit suppresses the flush and keeps the high part H in the accumulator. `accumMode` high on the next start keeps it, so that stream equals B*y + H over M+8 bits.
- R8: While a flush runs, `bitValid`, `bitIn`, `bitStart` and `bitLast` are ignored. The output stream is unchanged.
- R9: With `bitValid` low and no flush running, `prodValid` is 0 in the next cycle.
- R10: Multiplier bits are accepted on consecutive cycles without stalls. The first bit of a new multiply is accepted in the cycle right after the last flush cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcandLoad | input | 1 | Store `mcandIn` as the multiplicand |
| mcandIn | input | 8 | Multiplicand value |
| bitValid | input | 1 | A multiplier bit is offered this cycle |
| bitIn | input | 1 | Multiplier bit, least significant first |
| bitStart | input | 1 | Offered bit is the first of a multiplier |
| bitLast | input | 1 | Offered bit is the last of a multiplier |
| accumMode | input | 1 | On start: keep accumulator; on last: skip flush |
| prodValid | output | 1 | `prodBit` holds a product bit |
| prodBit | output | 1 | Serial product bit, least significant first |

## Verification
The assertions assume the caller raises `bitStart` only on the first bit of a multiplier. They also assume `bitLast` closes each multiplier before the next start, so the zero-output check after a cleared start with a 0 bit is meaningful. The directed tasks always pair start and last flags per multiplier. Stray control inputs appear only inside flush windows, where the requirements say they are ignored. Chained runs always set the keep flag on both the closing bit and the next start.

// File: rtl/serial_mac_pkg.sv
package serial_mac_pkg;
  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic step;   // accumulator shifts and one product bit is emitted
    logic clear;  // accumulator base is zero for this step
    logic addEn;  // multiplicand is gated into the adder
  } macStrobe_t;
endpackage

// File: rtl/serial_mac_ctrl.sv
module serial_mac_ctrl
  import serial_mac_pkg::*;
#(
  parameter int MC_W = 8,
  localparam int FLUSH_W = $clog2(MC_W + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       bitStart,
  input  logic       bitLast,
  input  logic       accumMode,
  output macStrobe_t strobe,
  output logic       flushing
);
  logic [FLUSH_W-1:0] flushCnt;
  logic               beat;

  assign flushing = (flushCnt != '0);
  assign beat     = bitValid && !flushing;

  always_comb begin
    strobe.step  = beat || flushing;
    strobe.clear = beat && bitStart && !accumMode;
    strobe.addEn = beat && bitIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flushCnt <= '0;
    end else if (beat && bitLast && !accumMode) begin
      flushCnt <= FLUSH_W'(MC_W);
    end else if (flushing) begin
      flushCnt <= flushCnt - 1'b1;
    end
  end
endmodule

// File: rtl/serial_mac_dp.sv
module serial_mac_dp
  import serial_mac_pkg::*;
#(
  parameter int MC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mcandLoad,
  input  logic [MC_W-1:0] mcandIn,
  input  macStrobe_t      strobe,
  output logic            prodValid,
  output logic            prodBit
);
  logic [MC_W-1:0] mcand;
  logic [MC_W-1:0] acc;
  logic [MC_W-1:0] base;
  logic [MC_W-1:0] gated;
  logic [MC_W:0]   sum;

  always_comb begin
    base  = strobe.clear ? '0 : acc;
    gated = mcand & {MC_W{strobe.addEn}};
    sum   = {1'b0, base} + {1'b0, gated};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand <= '0;
    end else if (mcandLoad) begin
      mcand <= mcandIn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      prodBit   <= 1'b0;
      prodValid <= 1'b0;
    end else begin
      prodValid <= strobe.step;
      if (strobe.step) begin
        acc     <= sum[MC_W:1];
        prodBit <= sum[0];
      end
    end
  end
endmodule

// File: rtl/serial_mac.sv
module serial_mac
  import serial_mac_pkg::*;
#(
  parameter int MC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mcandLoad,
  input  logic [MC_W-1:0] mcandIn,
  input  logic            bitValid,
  input  logic            bitIn,
  input  logic            bitStart,
  input  logic            bitLast,
  input  logic            accumMode,
  output logic            prodValid,
  output logic            prodBit
);
  macStrobe_t strobe;
  logic       flushing;

  serial_mac_ctrl #(.MC_W(MC_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .bitValid(bitValid), .bitIn(bitIn), .bitStart(bitStart),
    .bitLast(bitLast), .accumMode(accumMode),
    .strobe(strobe), .flushing(flushing)
  );

  serial_mac_dp #(.MC_W(MC_W)) dp_i (
    .clk(clk), .rst_n(rst_n),
    .mcandLoad(mcandLoad), .mcandIn(mcandIn),
    .strobe(strobe),
    .prodValid(prodValid), .prodBit(prodBit)
  );
endmodule

// File: rtl/serial_mac_chk.sv
module serial_mac_chk #(
  parameter int MC_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic bitValid,
  input logic bitIn,
  input logic bitStart,
  input logic accumMode,
  input logic flushing,
  input logic prodValid,
  input logic prodBit
);
  int unsigned flushRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flushRun <= 0;
    else if (flushing) flushRun <= flushRun + 1;
    else               flushRun <= 0;
  end

  AST_BEAT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bitValid && !flushing) |=> prodValid);  // R3

  AST_FLUSH_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> prodValid);  // R4

  AST_FLUSH_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flushing) |-> (flushRun == MC_W));  // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bitValid && !flushing && bitStart && !accumMode && !bitIn) |=> !prodBit);  // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bitValid && !flushing) |=> !prodValid);  // R9
endmodule

bind serial_mac serial_mac_chk #(.MC_W(MC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitIn(bitIn),
  .bitStart(bitStart), .accumMode(accumMode), .flushing(flushing),
  .prodValid(prodValid), .prodBit(prodBit)
);

// File: tb/serial_mac_tb_top.sv
`timescale 1ns/1ps
module serial_mac_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mcandLoad = 1'b0;
  logic [7:0] mcandIn = '0;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic       bitStart = 1'b0;
  logic       bitLast = 1'b0;
  logic       accumMode = 1'b0;
  logic       prodValid;
  logic       prodBit;

  int vecCnt = 0;
  int missCnt = 0;
  logic [63:0] capture = '0;
  int capCnt = 0;

  always #2.5 clk = ~clk;

  serial_mac dut_i (
    .clk(clk), .rst_n(rst_n), .mcandLoad(mcandLoad), .mcandIn(mcandIn),
    .bitValid(bitValid), .bitIn(bitIn), .bitStart(bitStart),
    .bitLast(bitLast), .accumMode(accumMode),
    .prodValid(prodValid), .prodBit(prodBit)
  );

  always @(negedge clk) begin
    if (prodValid === 1'b1) begin
      if (capCnt < 64) capture[capCnt] = prodBit;
      capCnt = capCnt + 1;
    end
  end

  initial begin
    #1000000;
    missCnt = missCnt + 1;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecCnt = vecCnt + 1;
    if (act !== exp) begin
      missCnt = missCnt + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic capClear();
    capture = '0;
    capCnt = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) begin
      @(negedge clk);
      mcandLoad = 0; bitValid = 0; bitIn = 0;
      bitStart = 0; bitLast = 0; accumMode = 0;
    end
  endtask

  task automatic loadMc(input logic [7:0] a);
    @(negedge clk);
    mcandLoad = 1; mcandIn = a; bitValid = 0;
    bitStart = 0; bitLast = 0; accumMode = 0;
  endtask

  task automatic beats(input logic [63:0] x, input int n, input bit keepS, input bit keepL);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mcandLoad = 0; bitValid = 1; bitIn = x[i];
      bitStart = (i == 0); bitLast = (i == n - 1);
      accumMode = ((i == 0) && keepS) || ((i == n - 1) && keepL);
    end
  endtask

  // flush window of 8 cycles; optional junk on inputs, optional load in last cycle
  task automatic flushWin(input bit junk, input bit loadNext, input logic [7:0] nextA);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bitValid = junk; bitIn = junk; bitStart = junk;
      bitLast = junk; accumMode = 0;
      mcandLoad = loadNext && (i == 7); mcandIn = nextA;
    end
  endtask

  task automatic checkStream(input string req, input int n, input logic [63:0] exp);
    logic [63:0] mask;
    mask = (n >= 64) ? '1 : ((64'd1 << n) - 1);
    check({req, " bit count"}, 64'(capCnt), 64'(n));
    check({req, " value"}, capture & mask, exp & mask);
  endtask

  task automatic plainMul(input string req, input logic [7:0] a, input logic [63:0] x, input int n);
    logic [63:0] e;
    e = 64'(a) * x;
    capClear();
    loadMc(a);
    beats(x, n, 1'b0, 1'b0);
    idle(12);
    checkStream(req, n + 8, e);
  endtask

  task automatic tReset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 prodValid in reset", 64'(prodValid), 64'd0);
    rst_n = 1;
    idle(2);
    check("R1 prodValid after reset", 64'(prodValid), 64'd0);
    // keep flag on start after reset: accumulator must already be zero
    capClear();
    loadMc(8'h9D);
    beats(64'h5B, 8, 1'b1, 1'b0);
    idle(12);
    checkStream("R1 keep after reset", 16, 64'(8'h9D) * 64'h5B);
  endtask

  task automatic tLatency();
    idle(2);
    check("R9 idle before beat", 64'(prodValid), 64'd0);
    loadMc(8'h11);
    beats(64'h1, 1, 1'b0, 1'b0);
    @(negedge clk);
    mcandLoad = 0; bitValid = 0; bitStart = 0; bitLast = 0; bitIn = 0;
    check("R3 valid one cycle after beat", 64'(prodValid), 64'd1);
    check("R3 first product bit", 64'(prodBit), 64'd1);
    idle(12);
  endtask

  task automatic tChain();
    logic [63:0] p1, p2;
    p1 = 64'(8'hC7) * 64'hB9;
    p2 = 64'(8'h5E) * 64'h2D + (p1 >> 8);
    capClear();
    loadMc(8'hC7);
    beats(64'hB9, 8, 1'b0, 1'b1);
    idle(4);
    checkStream("R7 chained first part", 8, p1);
    capClear();
    loadMc(8'h5E);
    beats(64'h2D, 8, 1'b1, 1'b0);
    idle(12);
    checkStream("R7 chained sum", 16, p2);
  endtask

  task automatic tClear();
    capClear();
    loadMc(8'hF3);
    beats(64'hE7, 8, 1'b0, 1'b1);  // leaves a nonzero high part
    idle(4);
    capClear();
    loadMc(8'h2A);
    beats(64'h6C, 8, 1'b0, 1'b0);  // start without keep: must clear
    idle(12);
    checkStream("R6 start clears", 16, 64'(8'h2A) * 64'h6C);
  endtask

  task automatic tJunk();
    capClear();
    loadMc(8'hB6);
    beats(64'h3D1, 10, 1'b0, 1'b0);
    flushWin(1'b1, 1'b0, 8'h00);
    idle(6);
    checkStream("R8 junk during flush", 18, 64'(8'hB6) * 64'h3D1);
  endtask

  task automatic tBackToBack();
    logic [63:0] e;
    e = (64'(8'h6F) * 64'h2B5) | ((64'(8'hD2) * 64'h1E7) << 18);
    capClear();
    loadMc(8'h6F);
    beats(64'h2B5, 10, 1'b0, 1'b0);
    flushWin(1'b0, 1'b1, 8'hD2);  // next multiplicand loaded in last flush cycle
    beats(64'h1E7, 10, 1'b0, 1'b0);
    idle(12);
    checkStream("R10 R2 back to back", 36, e);
  endtask

  task automatic tIdle();
    capClear();
    idle(20);
    check("R9 no output when idle", 64'(capCnt), 64'd0);
  endtask

  initial begin
    tReset();
    plainMul("R4 basic 2-bit", 8'hA5, 64'h3, 2);
    plainMul("R4 all ones 32-bit", 8'hFF, 64'hFFFF_FFFF, 32);
    plainMul("R5 single bit", 8'h80, 64'h1, 1);
    plainMul("R5 long 40-bit", 8'h3C, 64'h9A_5C3E_1027, 40);
    plainMul("R2 zero multiplicand", 8'h00, 64'hABCD, 16);
    tLatency();
    tChain();
    tClear();
    tJunk();
    tBackToBack();
    tIdle();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end
endmodule